// File: doc/BRIEF.md
# Full-Duplex Pause Frame Generator

This block decides when a full-duplex Ethernet transmitter must send a flow-control pause frame, and which pause time the frame carries. Two sources can ask for a frame. The first is a software request bit. The second is a receive-buffer-full flag. Serialising the frame and appending its CRC is left to the transmitter that consumes the offer. The transmitter puts a CRC on every frame it takes.

When the buffer-full flag triggers a frame, the block keeps its own countdown of the pause it advertised, in slot times. A programmable number of slot times before that pause runs out, it samples the flag again. If the buffer is still full, it renews the pause with a fresh frame. If the buffer has drained, it sends a frame with pause time zero, which releases the remote end at once.

Frames are offered on a valid/accept handshake. A software-requested frame produces a one-cycle clear pulse once the transmitter has taken it, so that the request bit can be reset.

Top module: `pause_frame_gen`

## Requirements
- R1: No frame is offered unless both flowEn and fullDuplex are 1. If either of them is 0 in a cycle, any offered or pending frame is withdrawn by the next cycle. An active buffer-full countdown is also abandoned, so re-enabling with the buffer not full produces no frame.
- R2: A 0-to-1 transition of swReq produces exactly one frame carrying pauseTime. Holding swReq at 1 produces no further frames. A new software frame needs swReq to return to 0 first.
- R3: reqClear is a one-cycle pulse in the cycle after a software-requested frame is accepted (frameReq and txAck both 1). It never pulses for a buffer-full frame.
- R4: When the block is idle and bufFull is 1, one frame carrying pauseTime is offered. The countdown is loaded with pauseTime.
- R5: On each slotTick during a countdown, the remaining count drops by one. On the tick that leaves it at or below the threshold, bufFull is sampled. If bufFull is 1, another frame carrying pauseTime is offered and the countdown reloads. This repeats for as long as the buffer stays full.
- R6: If bufFull is 0 at that sampling tick, a frame with pause time 0 is offered and the block returns to idle. Later ticks produce nothing, and a later bufFull of 1 starts again as in R4.
- R7: thrSel picks the threshold in slot times: 0 gives 4, 1 gives 28, 2 gives 144 and 3 gives 256.
- R8: While frameReq is 1 and txAck is 0 (with the block enabled), frameReq stays 1 and frameTime holds its value. After reset, frameReq and reqClear are 0.
- R9: When a buffer-full frame and a software frame are pending together, the buffer-full frame is offered first.
- R10: Changes of bufFull between sampling ticks of a countdown produce no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flowEn | input | 1 | Transmit flow-control enable |
| fullDuplex | input | 1 | Link is in full-duplex mode |
| swReq | input | 1 | Software pause request bit (level) |
| pauseTime | input | 16 | Programmed pause time in slot times |
| thrSel | input | 2 | Renewal threshold select |
| bufFull | input | 1 | Receive buffer full |
| slotTick | input | 1 | One-cycle pulse per slot time |
| txAck | input | 1 | Transmitter accepts the offered frame |
| frameReq | output | 1 | A pause frame is offered |
| frameTime | output | 16 | Pause time of the offered frame |
| reqClear | output | 1 | Pulse that clears the software request bit |

## Verification
A countdown that is off by a few slots shows at the ports as a renewal or release frame that arrives one or more slot ticks early or late. The bench walks every threshold setting with the pause set five slots above the threshold, so such an error surfaces on the exact tick. A stuck or mis-tracked idle/countdown state shows as extra frames on later ticks, or as a missing frame when the buffer fills again. A wrong source tag on the offered frame shows as a reqClear pulse that is missing or misplaced in the cycle after acceptance. That is visible within one cycle of the handshake.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

  localparam int TIME_W = 16;
  localparam int THR_W  = 9;

  typedef struct packed {
    logic countEn;
    logic loadCnt;
    logic issue;
    logic issueZero;
    logic issueSw;
    logic kill;
  } pfgStrobe_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_HOLD = 1'b1} pfgState_e;

  function automatic logic [THR_W-1:0] thrSlots(input logic [1:0] sel);
    case (sel)
      2'd0:    thrSlots = THR_W'(4);
      2'd1:    thrSlots = THR_W'(28);
      2'd2:    thrSlots = THR_W'(144);
      default: thrSlots = THR_W'(256);
    endcase
  endfunction

endpackage

// File: rtl/pfg_ctrl.sv
module pfg_ctrl
  import pfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       flowEn,
  input  logic       fullDuplex,
  input  logic       swReq,
  input  logic       bufFull,
  input  logic       slotHit,
  input  logic       frameBusy,
  output pfgStrobe_t strobe
);

  pfgState_e stateQ, stateD;
  logic autoPendQ, autoPendD;
  logic autoZeroQ, autoZeroD;
  logic swPendQ, swPendD;
  logic swBusyQ, swBusyD;

  logic linkOn;
  logic issueAuto, issueSwNow;
  logic loadNow;

  assign linkOn     = flowEn & fullDuplex;
  // a buffer-full frame outranks a software frame (R9)
  assign issueAuto  = linkOn & ~frameBusy & autoPendQ;
  assign issueSwNow = linkOn & ~frameBusy & swPendQ & ~autoPendQ;

  always_comb begin
    stateD    = stateQ;
    autoPendD = autoPendQ;
    autoZeroD = autoZeroQ;
    swPendD   = swPendQ;
    swBusyD   = swBusyQ;
    loadNow   = 1'b0;

    if (!linkOn) begin
      stateD    = ST_IDLE;
      autoPendD = 1'b0;
      autoZeroD = 1'b0;
      swPendD   = 1'b0;
      swBusyD   = 1'b0;
    end else begin
      if (issueAuto)  autoPendD = 1'b0;
      if (issueSwNow) swPendD   = 1'b0;

      case (stateQ)
        ST_IDLE: begin
          if (bufFull) begin
            stateD    = ST_HOLD;
            autoPendD = 1'b1;
            autoZeroD = 1'b0;
            loadNow   = 1'b1;
          end
        end
        ST_HOLD: begin
          if (slotHit) begin
            autoPendD = 1'b1;
            if (bufFull) begin
              autoZeroD = 1'b0;
              loadNow   = 1'b1;
            end else begin
              autoZeroD = 1'b1;
              stateD    = ST_IDLE;
            end
          end
        end
        default: stateD = ST_IDLE;
      endcase

      if (!swReq) begin
        swBusyD = 1'b0;
      end else if (!swBusyQ) begin
        swBusyD = 1'b1;
        swPendD = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      autoPendQ <= 1'b0;
      autoZeroQ <= 1'b0;
      swPendQ   <= 1'b0;
      swBusyQ   <= 1'b0;
    end else begin
      stateQ    <= stateD;
      autoPendQ <= autoPendD;
      autoZeroQ <= autoZeroD;
      swPendQ   <= swPendD;
      swBusyQ   <= swBusyD;
    end
  end

  always_comb begin
    strobe.countEn   = linkOn & (stateQ == ST_HOLD);
    strobe.loadCnt   = loadNow;
    strobe.issue     = issueAuto | issueSwNow;
    strobe.issueZero = issueAuto & autoZeroQ;
    strobe.issueSw   = issueSwNow;
    strobe.kill      = ~linkOn;
  end

endmodule

// File: rtl/pfg_dp.sv
module pfg_dp
  import pfg_pkg::*;
#(
  parameter int TW = TIME_W,
  parameter int HW = THR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  pfgStrobe_t    strobe,
  input  logic [TW-1:0] pauseTime,
  input  logic [1:0]    thrSel,
  input  logic          slotTick,
  input  logic          txAck,
  output logic          slotHit,
  output logic          frameReq,
  output logic [TW-1:0] frameTime,
  output logic          reqClear
);

  localparam int CW = (TW > HW) ? TW : HW;

  logic [TW-1:0] remainQ;
  logic [TW-1:0] remainDec;
  logic [HW-1:0] thrNow;
  logic          frameIsSwQ;
  logic          handoff;

  assign thrNow    = thrSlots(thrSel);
  assign remainDec = (remainQ == '0) ? '0 : remainQ - TW'(1);
  assign slotHit   = strobe.countEn & slotTick &
                     (CW'(remainDec) <= CW'(thrNow));
  assign handoff   = frameReq & txAck;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remainQ <= '0;
    end else if (strobe.loadCnt) begin
      remainQ <= pauseTime;
    end else if (strobe.countEn && slotTick) begin
      remainQ <= remainDec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameReq   <= 1'b0;
      frameTime  <= '0;
      frameIsSwQ <= 1'b0;
      reqClear   <= 1'b0;
    end else begin
      reqClear <= handoff & frameIsSwQ;
      if (strobe.kill || handoff) begin
        frameReq <= 1'b0;
      end else if (strobe.issue) begin
        frameReq   <= 1'b1;
        frameTime  <= strobe.issueZero ? '0 : pauseTime;
        frameIsSwQ <= strobe.issueSw;
      end
    end
  end

endmodule

// File: rtl/pause_frame_gen.sv
module pause_frame_gen
  import pfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              flowEn,
  input  logic              fullDuplex,
  input  logic              swReq,
  input  logic [TIME_W-1:0] pauseTime,
  input  logic [1:0]        thrSel,
  input  logic              bufFull,
  input  logic              slotTick,
  input  logic              txAck,
  output logic              frameReq,
  output logic [TIME_W-1:0] frameTime,
  output logic              reqClear
);

  pfgStrobe_t strobe;
  logic       slotHit;

  pfg_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .flowEn     (flowEn),
    .fullDuplex (fullDuplex),
    .swReq      (swReq),
    .bufFull    (bufFull),
    .slotHit    (slotHit),
    .frameBusy  (frameReq),
    .strobe     (strobe)
  );

  pfg_dp #(.TW(TIME_W), .HW(THR_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pauseTime (pauseTime),
    .thrSel    (thrSel),
    .slotTick  (slotTick),
    .txAck     (txAck),
    .slotHit   (slotHit),
    .frameReq  (frameReq),
    .frameTime (frameTime),
    .reqClear  (reqClear)
  );

endmodule

// File: rtl/pause_frame_gen_chk.sv
module pause_frame_gen_chk
  import pfg_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              flowEn,
  input logic              fullDuplex,
  input logic              txAck,
  input logic              frameReq,
  input logic [TIME_W-1:0] frameTime,
  input logic              reqClear
);

  AST_OFF_NO_OFFER: assert property (@(posedge clk) disable iff (!rstN)
    !$past(flowEn && fullDuplex) |-> !frameReq); // R1

  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (frameReq && !txAck && flowEn && fullDuplex) |=> (frameReq && $stable(frameTime))); // R8

  AST_CLEAR_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    reqClear |-> $past(frameReq && txAck)); // R3

  AST_CLEAR_FRAME_GONE: assert property (@(posedge clk) disable iff (!rstN)
    reqClear |-> !frameReq); // R3

endmodule

bind pause_frame_gen pause_frame_gen_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .flowEn     (flowEn),
  .fullDuplex (fullDuplex),
  .txAck      (txAck),
  .frameReq   (frameReq),
  .frameTime  (frameTime),
  .reqClear   (reqClear)
);

// File: tb/pause_frame_gen_tb_top.sv
module pause_frame_gen_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] t;
    bit          sw;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flowEn = 1'b0;
  logic        fullDuplex = 1'b0;
  logic        swReq = 1'b0;
  logic [15:0] pauseTime = '0;
  logic [1:0]  thrSel = '0;
  logic        bufFull = 1'b0;
  logic        slotTick = 1'b0;
  logic        txAck = 1'b0;
  logic        frameReq;
  logic [15:0] frameTime;
  logic        reqClear;

  int testsRun = 0;
  int testsFailed = 0;
  bit ackBlock = 1'b0;
  int ackDelay = 0;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pause_frame_gen dut_i (
    .clk(clk), .rstN(rstN), .flowEn(flowEn), .fullDuplex(fullDuplex),
    .swReq(swReq), .pauseTime(pauseTime), .thrSel(thrSel), .bufFull(bufFull),
    .slotTick(slotTick), .txAck(txAck), .frameReq(frameReq),
    .frameTime(frameTime), .reqClear(reqClear)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("[TB] FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pushExp(input logic [15:0] t, input bit sw, input string tag);
    expItem_t it;
    it.t = t; it.sw = sw; it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor / scoreboard: accepts offered frames and compares against the queue
  initial begin : monitor
    bit clrDue = 1'b0;
    bit clrExp = 1'b0;
    string clrTag = "";
    int waitCnt = 0;
    logic [15:0] holdTime = '0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (clrDue) begin
          check(reqClear == clrExp, {clrTag, " R3 reqClear after accept"}, reqClear, clrExp);
          clrDue = 1'b0;
        end else if (reqClear) begin
          check(1'b0, "R3 stray reqClear", 1, 0);
        end
        if (txAck) begin
          txAck = 1'b0;
          waitCnt = 0;
        end else if (!ackBlock && frameReq) begin
          if (waitCnt == 0) holdTime = frameTime;
          if (waitCnt < ackDelay) begin
            if (waitCnt > 0)
              check(frameTime == holdTime, "R8 frameTime held", frameTime, holdTime);
            waitCnt++;
          end else begin
            if (expQ.size() == 0) begin
              check(1'b0, "R10 R2 unexpected frame", frameTime, -1);
              clrExp = 1'b0;
              clrTag = "R2";
            end else begin
              expItem_t it;
              it = expQ.pop_front();
              check(frameTime == it.t, {it.tag, " frame time"}, frameTime, it.t);
              clrExp = it.sw;
              clrTag = it.tag;
            end
            clrDue = 1'b1;
            txAck = 1'b1;
          end
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk); slotTick = 1'b1;
      @(negedge clk); slotTick = 1'b0;
      cyc(3);
    end
  endtask

  task automatic waitDrain(input string tag);
    int k = 0;
    while ((expQ.size() != 0 || frameReq || txAck) && k < 400) begin
      @(negedge clk);
      k++;
    end
    cyc(3);
    check(expQ.size() == 0, {tag, " expected frame delivered"}, expQ.size(), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("[TB] FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin : stim
    cyc(4);
    check(frameReq == 1'b0, "R8 reset frameReq", frameReq, 0);
    check(reqClear == 1'b0, "R8 reset reqClear", reqClear, 0);
    rstN = 1'b1;
    cyc(2);

    // R2 / R3: software request, held bit gives one frame
    flowEn = 1'b1; fullDuplex = 1'b1; pauseTime = 16'h1234;
    pushExp(16'h1234, 1'b1, "R2");
    swReq = 1'b1;
    waitDrain("R2");
    cyc(10);
    check(frameReq == 1'b0, "R2 held bit no repeat", frameReq, 0);
    swReq = 1'b0; cyc(3);
    // R8: slow acceptance, value must hold
    ackDelay = 4; pauseTime = 16'h0040;
    pushExp(16'h0040, 1'b1, "R8");
    swReq = 1'b1;
    waitDrain("R8");
    swReq = 1'b0; ackDelay = 0; cyc(3);

    // R1: gating
    flowEn = 1'b0; swReq = 1'b1; cyc(20);
    check(frameReq == 1'b0, "R1 flowEn off sw", frameReq, 0);
    swReq = 1'b0; flowEn = 1'b1; fullDuplex = 1'b0; bufFull = 1'b1; cyc(20);
    check(frameReq == 1'b0, "R1 half duplex full", frameReq, 0);
    bufFull = 1'b0; cyc(2); fullDuplex = 1'b1; cyc(3);

    // R4 / R5 / R10 / R6 with threshold 4, pause 10: sample on 6th tick
    thrSel = 2'd0; pauseTime = 16'd10;
    pushExp(16'd10, 1'b0, "R4");
    bufFull = 1'b1;
    waitDrain("R4");
    tick(3);
    bufFull = 1'b0; cyc(2); bufFull = 1'b1; cyc(2);
    tick(2);
    check(frameReq == 1'b0 && expQ.size() == 0, "R10 no early frame", frameReq, 0);
    pushExp(16'd10, 1'b0, "R5");
    tick(1);
    waitDrain("R5");
    tick(5);
    check(frameReq == 1'b0, "R5 no early second renewal", frameReq, 0);
    pushExp(16'd10, 1'b0, "R5");
    tick(1);
    waitDrain("R5 repeat");
    bufFull = 1'b0;
    tick(5);
    check(frameReq == 1'b0, "R6 no early release", frameReq, 0);
    pushExp(16'd0, 1'b0, "R6");
    tick(1);
    waitDrain("R6");
    tick(8);
    check(frameReq == 1'b0, "R6 idle after release", frameReq, 0);
    pushExp(16'd10, 1'b0, "R6");
    bufFull = 1'b1;
    waitDrain("R6 retrigger");
    bufFull = 1'b0;
    tick(5);
    pushExp(16'd0, 1'b0, "R6");
    tick(1);
    waitDrain("R6 second release");

    // R7: every threshold, pause = threshold + 5 -> release on 5th tick
    for (int s = 0; s < 4; s++) begin
      int thr;
      thr = (s == 0) ? 4 : (s == 1) ? 28 : (s == 2) ? 144 : 256;
      thrSel = 2'(s);
      pauseTime = 16'(thr + 5);
      pushExp(16'(thr + 5), 1'b0, "R7");
      bufFull = 1'b1;
      waitDrain("R7 start");
      bufFull = 1'b0;
      tick(4);
      check(frameReq == 1'b0, "R7 no release before threshold", s, thr);
      pushExp(16'd0, 1'b0, "R7");
      tick(1);
      waitDrain("R7 release");
    end

    // R9: both sources at once, buffer-full frame first
    thrSel = 2'd0; pauseTime = 16'd10;
    ackBlock = 1'b1;
    pushExp(16'd10, 1'b0, "R9");
    pushExp(16'd10, 1'b1, "R9");
    bufFull = 1'b1; swReq = 1'b1;
    cyc(4);
    ackBlock = 1'b0;
    waitDrain("R9");
    swReq = 1'b0;
    bufFull = 1'b0;
    pushExp(16'd0, 1'b0, "R9");
    tick(6);
    waitDrain("R9 release");

    // R1: withdrawal of an offer and abandonment of a countdown
    pushExp(16'd10, 1'b0, "R1");
    bufFull = 1'b1;
    waitDrain("R1 start");
    ackBlock = 1'b1;
    swReq = 1'b1;
    cyc(5);
    check(frameReq == 1'b1, "R1 offer present", frameReq, 1);
    flowEn = 1'b0;
    cyc(2);
    check(frameReq == 1'b0, "R1 offer withdrawn", frameReq, 0);
    swReq = 1'b0; bufFull = 1'b0;
    cyc(2);
    flowEn = 1'b1; ackBlock = 1'b0;
    tick(10);
    check(frameReq == 1'b0 && expQ.size() == 0, "R1 countdown abandoned", frameReq, 0);
    cyc(5);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule